// File: doc/BRIEF.md
# Self-Gating Counter Prescaler

This block sits in front of a frequency counter and prescales an asynchronous error-frequency signal. The signal is synchronized into the system clock, and only its falling edges are counted. A selectable input path feeds a first divider section. The top bit of that section returns through a second gated path into a second, three-bit divider section. The middle bit of the second section is the divide-by-eight feed for the next counter stage. Its top bit is the divide-by-sixteen flag.

The flag does more than report. When it sets, it shuts both input paths, so the block opens one measurement window per clear instead of dividing without end. The host pulses the clear to start a count cycle. It can then watch the flag to learn when the window has closed. Of the selectable sources only the error signal is wired. Every other source code reads a constant low level.

Top module: `fe_window_prescaler`

## Requirements
- R1: A high level on `host_clr` at a rising clock edge returns every divider stage to zero, so `tap_feed` and `win_done` both read 0 afterwards. After reset both outputs are also 0.
- R2: Only falling edges of `fe_in` advance the count. A rising edge changes no divider state.
- R3: Counting from a clear, `tap_feed` is 0 after 0 to 3 falling edges, 1 after 4 to 7, and 0 after the 8th.
- R4: `win_done` is 0 after fewer than 8 falling edges since the clear and 1 from the 8th on. When it rises, `tap_feed` is 0.
- R5: Once `win_done` is 1, further edges on `fe_in` change neither output until the next clear.
- R6: `src_sel` value 0 selects `fe_in`. The values 1 to 3 select reserved sources tied low. While a reserved code is selected, edges on `fe_in` are not counted. The count already held is neither lost nor advanced.
- R7: A clear in the middle of a window restarts the window from zero. While `host_clr` stays high, no edge is counted.
- R8: With the default two synchronizer stages, a falling edge of `fe_in` that completes the 4th count changes `tap_feed` on the 4th rising clock edge after the input change, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_clr | input | 1 | Synchronous clear at the start of a count cycle |
| src_sel | input | 2 | Source code; 0 is the error signal, others are reserved and read low |
| fe_in | input | 1 | Asynchronous error-frequency input |
| tap_feed | output | 1 | Divide-by-eight feed for the downstream counter |
| win_done | output | 1 | Divide-by-sixteen flag; high when the window has closed |

## Verification
The assertions assume that `src_sel` changes only while `fe_in` has been low for long enough to reach the synchronizer output. If the code moves away from the error source while the path is high, a genuine falling edge appears at the multiplexer. The bench keeps to this by switching sources only after `fe_in` has rested low for several clocks. It also holds each level of `fe_in` for six clocks, so every edge clears the synchronizer and both divider sections before the next one arrives. Clear pulses are issued only while `fe_in` is low. One test places a falling edge at a known clock phase so the pipeline latency can be counted exactly.

// File: rtl/pscl_pkg.sv
package pscl_pkg;

   // Width of a select field able to address n sources (at least one bit).
   function automatic int sel_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

   // Number of counted input edges that close one window.
   function automatic int window_edges(input int pre_bits, input int div_bits);
      return 1 << (pre_bits + div_bits - 1);
   endfunction

endpackage

// File: rtl/pscl_sync.sv
module pscl_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("pscl_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d};
   end

   assign q = chain_q[STAGES-1];

endmodule

// File: rtl/pscl_path.sv
// Gated selectable path with falling-edge detection in the clock domain.
module pscl_path #(
   parameter int NUM_IN = 1,
   parameter int SEL_W  = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              gate_off,
   input  logic [SEL_W-1:0]  sel,
   input  logic [NUM_IN-1:0] src,
   output logic              fall
);

   generate
      if (NUM_IN < 1) begin : g_bad_num
         $error("pscl_path: NUM_IN must be at least 1");
      end
      if ((1 << SEL_W) < NUM_IN) begin : g_bad_sel
         $error("pscl_path: SEL_W too narrow for NUM_IN");
      end
   endgenerate

   logic picked;
   logic live;
   logic prev_q;

   // Codes with no source behind them read low.
   always_comb begin
      picked = 1'b0;
      for (int i = 0; i < NUM_IN; i++) begin
         if (sel == SEL_W'(i)) picked = src[i];
      end
   end

   assign live = picked & ~gate_off;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   prev_q <= 1'b0;
      else if (clr) prev_q <= 1'b0;
      else          prev_q <= live;
   end

   assign fall = prev_q & ~live & ~clr;

   AST_PATH_SHUT: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_off && $past(gate_off)) |-> !fall); // R5

   AST_PATH_CLR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      clr |-> !fall); // R7

endmodule

// File: rtl/pscl_section.sv
// One divider section: advances on each step pulse, cleared by clr.
module pscl_section #(
   parameter int WIDTH = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             step,
   output logic [WIDTH-1:0] q
);

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("pscl_section: WIDTH must be at least 1");
      end
      else if (WIDTH == 1) begin : g_toggle
         logic t_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    t_q <= 1'b0;
            else if (clr)  t_q <= 1'b0;
            else if (step) t_q <= ~t_q;
         end
         assign q = t_q;
      end
      else begin : g_count
         logic [WIDTH-1:0] c_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    c_q <= '0;
            else if (clr)  c_q <= '0;
            else if (step) c_q <= c_q + WIDTH'(1);
         end
         assign q = c_q;
      end
   endgenerate

   AST_SECTION_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (q == '0)); // R1

   AST_SECTION_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !step) |=> $stable(q)); // R2

endmodule

// File: rtl/fe_window_prescaler.sv
module fe_window_prescaler #(
   parameter int SYNC_STAGES = 2,
   parameter int NUM_SRC     = 4,
   parameter int ERR_SRC     = 0,
   parameter int PRE_BITS    = 1,
   parameter int DIV_BITS    = 3,
   parameter int FEED_TAP    = 1,
   localparam int SEL_W      = pscl_pkg::sel_width(NUM_SRC)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             host_clr,
   input  logic [SEL_W-1:0] src_sel,
   input  logic             fe_in,
   output logic             tap_feed,
   output logic             win_done
);

   localparam int              WIN_EDGES = pscl_pkg::window_edges(PRE_BITS, DIV_BITS);
   localparam logic [SEL_W-1:0] ERR_CODE = SEL_W'(ERR_SRC);

   generate
      if (ERR_SRC < 0 || ERR_SRC >= NUM_SRC) begin : g_bad_err
         $error("fe_window_prescaler: ERR_SRC outside source range");
      end
      if (DIV_BITS < 2) begin : g_bad_div
         $error("fe_window_prescaler: DIV_BITS must be at least 2");
      end
      if (PRE_BITS < 1) begin : g_bad_pre
         $error("fe_window_prescaler: PRE_BITS must be at least 1");
      end
      if (FEED_TAP < 0 || FEED_TAP >= DIV_BITS - 1) begin : g_bad_tap
         $error("fe_window_prescaler: FEED_TAP must sit below the gating bit");
      end
      if (WIN_EDGES < 2) begin : g_bad_win
         $error("fe_window_prescaler: window too short");
      end
   endgenerate

   logic                 fe_sync;
   logic [NUM_SRC-1:0]   src_vec;
   logic                 fall_a;
   logic                 fall_b;
   logic [PRE_BITS-1:0]  pre_q;
   logic [DIV_BITS-1:0]  div_q;

   pscl_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (fe_in),
      .q     (fe_sync)
   );

   // Only the error source is wired; reserved sources read low.
   generate
      for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
         if (i == ERR_SRC) begin : g_live
            assign src_vec[i] = fe_sync;
         end
         else begin : g_tied
            assign src_vec[i] = 1'b0;
         end
      end
   endgenerate

   pscl_path #(.NUM_IN(NUM_SRC), .SEL_W(SEL_W)) u_path_in (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (host_clr),
      .gate_off (win_done),
      .sel      (src_sel),
      .src      (src_vec),
      .fall     (fall_a)
   );

   pscl_section #(.WIDTH(PRE_BITS)) u_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (host_clr),
      .step  (fall_a),
      .q     (pre_q)
   );

   // Top bit of the first section loops back through the second path.
   pscl_path #(.NUM_IN(1), .SEL_W(1)) u_path_loop (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (host_clr),
      .gate_off (win_done),
      .sel      (1'b0),
      .src      (pre_q[PRE_BITS-1]),
      .fall     (fall_b)
   );

   pscl_section #(.WIDTH(DIV_BITS)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (host_clr),
      .step  (fall_b),
      .q     (div_q)
   );

   assign win_done = div_q[DIV_BITS-1];
   assign tap_feed = div_q[FEED_TAP];

   AST_CLR_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
      host_clr |=> (!tap_feed && !win_done)); // R1

   AST_WIN_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (win_done && !host_clr) |=> ($stable(div_q) && $stable(pre_q))); // R5

   AST_FLAG_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(win_done) |-> (!tap_feed && (pre_q == '0))); // R4

   AST_RESERVED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      ((src_sel != ERR_CODE) && ($past(src_sel) != ERR_CODE)) |-> !fall_a); // R6

   AST_LOOP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      fall_b |-> (pre_q[PRE_BITS-1] == 1'b0)); // R3

endmodule

// File: tb/fe_window_prescaler_bench.sv
`timescale 1ns/1ps
module fe_window_prescaler_bench;

   localparam int HALF = 6;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       host_clr = 1'b0;
   logic [1:0] src_sel = 2'd0;
   logic       fe_in = 1'b0;
   logic       tap_feed;
   logic       win_done;

   int  n_vec = 0;
   int  n_bad = 0;
   bit  done  = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   fe_window_prescaler u_fe_window_prescaler (
      .clk      (clk),
      .rst_n    (rst_n),
      .host_clr (host_clr),
      .src_sel  (src_sel),
      .fe_in    (fe_in),
      .tap_feed (tap_feed),
      .win_done (win_done)
   );

   task automatic chk(input string req, input string what, input logic act, input logic exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
      end
   endtask

   task automatic wait_neg(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // One full input cycle ending with a falling edge and settle time.
   task automatic pulse_fe();
      fe_in = 1'b1; wait_neg(HALF);
      fe_in = 1'b0; wait_neg(HALF);
   endtask

   task automatic do_clear();
      @(negedge clk); host_clr = 1'b1;
      @(negedge clk); host_clr = 1'b0;
      wait_neg(2);
   endtask

   function automatic logic exp_feed(input int n);
      int c = (n > 8) ? 8 : n;
      return logic'((c >> 2) & 1);
   endfunction

   task automatic t_reset();
      chk("R1", "feed after reset", tap_feed, 1'b0);
      chk("R1", "done after reset", win_done, 1'b0);
   endtask

   task automatic t_window();
      do_clear();
      for (int n = 1; n <= 12; n++) begin
         pulse_fe();
         if (n <= 8) begin
            chk("R3", $sformatf("feed after %0d edges", n), tap_feed, exp_feed(n));
            chk("R4", $sformatf("done after %0d edges", n), win_done, logic'(n >= 8));
         end else begin
            chk("R5", $sformatf("feed frozen after %0d edges", n), tap_feed, 1'b0);
            chk("R5", $sformatf("done held after %0d edges", n), win_done, 1'b1);
         end
      end
      do_clear();
      chk("R1", "feed after clear of closed window", tap_feed, 1'b0);
      chk("R1", "done after clear of closed window", win_done, 1'b0);
   endtask

   task automatic t_rising();
      do_clear();
      for (int i = 0; i < 3; i++) pulse_fe();
      fe_in = 1'b1; wait_neg(HALF);
      chk("R2", "rising edge not counted", tap_feed, 1'b0);
      fe_in = 1'b0; wait_neg(HALF);
      chk("R2", "following fall counted", tap_feed, 1'b1);
   endtask

   task automatic t_latency();
      do_clear();
      for (int i = 0; i < 3; i++) pulse_fe();
      fe_in = 1'b1; wait_neg(HALF);
      fe_in = 1'b0;
      for (int i = 0; i < 3; i++) @(posedge clk);
      @(negedge clk);
      chk("R8", "feed before 4th clock", tap_feed, 1'b0);
      @(posedge clk); @(negedge clk);
      chk("R8", "feed at 4th clock", tap_feed, 1'b1);
      wait_neg(HALF);
   endtask

   task automatic t_reserved();
      do_clear();
      pulse_fe();
      src_sel = 2'd1;
      wait_neg(2);
      for (int i = 0; i < 8; i++) pulse_fe();
      chk("R6", "feed with reserved code 1", tap_feed, 1'b0);
      chk("R6", "done with reserved code 1", win_done, 1'b0);
      src_sel = 2'd3;
      wait_neg(2);
      for (int i = 0; i < 8; i++) pulse_fe();
      chk("R6", "done with reserved code 3", win_done, 1'b0);
      src_sel = 2'd0;
      wait_neg(2);
      for (int i = 0; i < 2; i++) pulse_fe();
      chk("R6", "feed after 3 total edges", tap_feed, 1'b0);
      pulse_fe();
      chk("R6", "count kept across reserved codes", tap_feed, 1'b1);
   endtask

   task automatic t_midclear();
      do_clear();
      for (int i = 0; i < 5; i++) pulse_fe();
      chk("R3", "feed mid window", tap_feed, 1'b1);
      do_clear();
      chk("R7", "feed after mid clear", tap_feed, 1'b0);
      for (int i = 0; i < 4; i++) pulse_fe();
      chk("R7", "feed after restart", tap_feed, 1'b1);
      chk("R7", "done after restart", win_done, 1'b0);
      @(negedge clk); host_clr = 1'b1;
      for (int i = 0; i < 6; i++) pulse_fe();
      chk("R7", "feed while clear held", tap_feed, 1'b0);
      chk("R7", "done while clear held", win_done, 1'b0);
      host_clr = 1'b0;
      wait_neg(2);
      for (int i = 0; i < 3; i++) pulse_fe();
      chk("R7", "feed 3 edges after release", tap_feed, 1'b0);
      pulse_fe();
      chk("R7", "feed 4 edges after release", tap_feed, 1'b1);
   endtask

   initial begin
      wait_neg(4);
      rst_n = 1'b1;
      wait_neg(2);
      t_reset();
      t_window();
      t_rising();
      t_latency();
      t_reserved();
      t_midclear();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

endmodule